// File: doc/BRIEF.md
# Code Density Nonlinearity Calculator

This block measures the linearity of a time-to-digital converter by code density. The converter is fed hits whose arrival times are spread uniformly, so a perfect converter would fill every fine-time bin equally. The block keeps one occupancy histogram per input channel, with one bin for each fine code across a single 128-bin period of the interpolating delay line. Each accepted hit adds one to the bin selected by its channel and code, and a running total per channel is updated with it.

On a compute command the histogram of one channel is frozen. The block takes the flat mean as the channel total shifted right by the bin-index width. It then walks the bins in ascending order and derives each bin's differential nonlinearity: the count's distance from the mean, divided by the mean, in signed fixed point. The integral nonlinearity is the running sum of those values from bin 0 upward. Both results are held in a result buffer. A clear command empties every histogram. Counts, DNL and INL are read through a one-cycle-latency readout port, so software can build correction tables from them.

Top module: `code_density_nl`

## Requirements
- R1: After reset, every bin count of every channel reads 0, `ready` is 1, and `done`, `sat_flag` and `drop_count` are 0. A hit presented with `hit_valid` while `ready` is 1 adds exactly one to the bin addressed by `hit_chan` and `hit_code`.
- R2: A bin at its maximum value 2^CNT_W-1 keeps that value when another hit addresses it, and `sat_flag` rises. `sat_flag` stays 1 until a clear command is accepted or reset is applied.
- R3: A clear command accepted while `ready` is 1 drives `ready` low for exactly 128 cycles. After that every bin of every channel reads 0.
- R4: A hit presented while `ready` is 0 changes no bin. It raises `drop_count` by exactly one, and `drop_count` stops at its maximum value. No other event changes `drop_count` except reset.
- R5: For the selected channel, mean = floor(total/128). Each bin's DNL is sign(count-mean) × min(floor(|count-mean|×256/mean), 2^(DNL_W-1)-1). This is a two's-complement value with 8 fractional bits. It is 0 when mean is 0.
- R6: The INL of bin k is the signed sum of the DNL values of bins 0 through k, with 8 fractional bits.
- R7: `done` rises in the cycle `ready` returns at the end of a compute. It is only ever 1 while `ready` is 1, and it falls when the next clear or compute command is accepted.
- R8: `ready` is 0 from the cycle after a compute command is accepted until the compute ends, and no bin count changes during that time.
- R9: When clear and compute commands arrive in the same cycle, only the clear is performed.
- R10: `rd_count`, `rd_dnl` and `rd_inl` show the values addressed by `rd_chan` and `rd_bin` one cycle after those inputs are applied. DNL and INL always come from the most recent compute.
- R11: Hits on one channel leave the histograms of all other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_chan | input | $clog2(NUM_CH) | Channel of the hit |
| hit_code | input | $clog2(NUM_BINS) | Fine time code of the hit |
| clear_req | input | 1 | Empty all histograms (priority over compute) |
| compute_req | input | 1 | Start DNL/INL computation |
| compute_chan | input | $clog2(NUM_CH) | Channel to compute |
| rd_chan | input | $clog2(NUM_CH) | Readout channel for counts |
| rd_bin | input | $clog2(NUM_BINS) | Readout bin |
| rd_count | output | CNT_W | Bin count, one cycle after address |
| rd_dnl | output | DNL_W | Signed DNL of bin, 8 fractional bits |
| rd_inl | output | DNL_W+$clog2(NUM_BINS) | Signed INL of bin, 8 fractional bits |
| ready | output | 1 | Idle, hits are accepted |
| done | output | 1 | Last compute finished |
| sat_flag | output | 1 | Sticky: some bin saturated |
| drop_count | output | DROP_W | Hits dropped while busy, saturating |

## Verification
Some rules are checked every cycle by the assertions. These are the exact 128-cycle length of a clear, `ready` falling after each accepted command, the drop counter stepping only on hits that arrive while busy, the stickiness of the saturation flag and its reset by clear, and `done` appearing only while idle. Other results only show up when the bench reads values back after its scenarios and compares them with its model. These are the bin contents themselves, channel isolation, the DNL arithmetic including the clamp and the zero-mean case, the INL summation, and the freezing of counts during a compute.

// File: rtl/cdh_pkg.sv
// Package: shared types of the code density nonlinearity calculator.
// Assumes: nothing beyond IEEE 1800-2017.
package cdh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD,
        ST_DIV,
        ST_STORE
    } cdh_state_e;
endpackage

// File: rtl/cdh_bank.sv
// Module: one channel's occupancy histogram with a running hit total.
// A bin update is a single-cycle read-modify-write on a flop array. Bins stop
// at their maximum and report the overflow attempt. Two combinational read
// ports serve readout and computation.
// Assumes: clr_en and inc_en are never high together.
module cdh_bank #(
    parameter int NUM_BINS = 128,
    parameter int CNT_W    = 24,
    parameter int BIN_W    = 7,
    parameter int TOT_W    = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [BIN_W-1:0] clr_addr,
    input  logic             inc_en,
    input  logic [BIN_W-1:0] inc_addr,
    input  logic [BIN_W-1:0] rd_a_addr,
    output logic [CNT_W-1:0] rd_a_data,
    input  logic [BIN_W-1:0] rd_b_addr,
    output logic [CNT_W-1:0] rd_b_data,
    output logic [TOT_W-1:0] total,
    output logic             sat_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [NUM_BINS];
    logic [TOT_W-1:0] tot_q;
    logic             at_max;

    // Purpose: detect an increment aimed at a full bin.
    always_comb begin
        at_max  = (cnt_q[inc_addr] == CNT_MAX);
        sat_hit = inc_en && at_max;
    end

    // Purpose: clear or increment bins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BINS; i++) cnt_q[i] <= '0;
        end else if (clr_en) begin
            cnt_q[clr_addr] <= '0;
        end else if (inc_en && !at_max) begin
            cnt_q[inc_addr] <= cnt_q[inc_addr] + 1'b1;
        end
    end

    // Purpose: keep the hit total equal to the sum of the bins.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tot_q <= '0;
        else if (clr_en)            tot_q <= '0;
        else if (inc_en && !at_max) tot_q <= tot_q + 1'b1;
    end

    assign rd_a_data = cnt_q[rd_a_addr];
    assign rd_b_data = cnt_q[rd_b_addr];
    assign total     = tot_q;
endmodule

// File: rtl/cdh_divider.sv
// Module: serial restoring unsigned divider, one quotient bit per cycle.
// A start pulse latches the operands. After NUM_W cycles done pulses for one
// cycle, and quot then holds its value until the next start.
// Assumes: den is non-zero at start.
module cdh_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [NUM_W-1:0]  quo_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              done_q;
    logic [DEN_W:0]    shifted;
    logic [DEN_W:0]    trial;
    logic              fits;

    // Purpose: shift in the next dividend bit and try a subtraction.
    always_comb begin
        shifted = {rem_q, quo_q[NUM_W-1]};
        trial   = shifted - {1'b0, den_q};
        fits    = (shifted >= {1'b0, den_q});
    end

    // Purpose: iterate the restoring division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            rem_q  <= '0;
            den_q  <= den;
            quo_q  <= num;
            step_q <= STEP_W'(NUM_W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
            quo_q  <= {quo_q[NUM_W-2:0], fits};
            step_q <= step_q - 1'b1;
            if (step_q == STEP_W'(1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign quot = quo_q;
endmodule

// File: rtl/cdh_result.sv
// Module: per-bin DNL and INL result buffer for the last computed channel.
// It has one write port and one combinational read port.
// Assumes: writes come only from the compute sequence.
module cdh_result #(
    parameter int NUM_BINS = 128,
    parameter int BIN_W    = 7,
    parameter int DNL_W    = 16,
    parameter int INL_W    = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BIN_W-1:0] wr_addr,
    input  logic [DNL_W-1:0] wr_dnl,
    input  logic [INL_W-1:0] wr_inl,
    input  logic [BIN_W-1:0] rd_addr,
    output logic [DNL_W-1:0] rd_dnl,
    output logic [INL_W-1:0] rd_inl
);
    logic [DNL_W-1:0] dnl_q [NUM_BINS];
    logic [INL_W-1:0] inl_q [NUM_BINS];

    // Purpose: store one bin's results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BINS; i++) begin
                dnl_q[i] <= '0;
                inl_q[i] <= '0;
            end
        end else if (wr_en) begin
            dnl_q[wr_addr] <= wr_dnl;
            inl_q[wr_addr] <= wr_inl;
        end
    end

    assign rd_dnl = dnl_q[rd_addr];
    assign rd_inl = inl_q[rd_addr];
endmodule

// File: rtl/cdh_ctrl.sv
// Module: sequencer for clear and compute, with the status flags.
// Clear walks all bin addresses, one per cycle, over every channel at once.
// Compute walks the bins of one channel in order: load the count, divide the
// deviation by the mean, clamp, accumulate INL, store.
// Assumes: NUM_BINS is a power of two and NUM_W >= DNL_W.
module cdh_ctrl
    import cdh_pkg::*;
#(
    parameter int NUM_BINS = 128,
    parameter int CNT_W    = 24,
    parameter int FRAC_W   = 8,
    parameter int DNL_W    = 16,
    parameter int DROP_W   = 16,
    parameter int CH_W     = 3,
    parameter int BIN_W    = 7,
    parameter int NUM_W    = 32,
    parameter int INL_W    = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_req,
    input  logic              compute_req,
    input  logic [CH_W-1:0]   compute_chan,
    input  logic              hit_valid,
    input  logic              sat_any,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic [CNT_W-1:0]  cur_mean,
    input  logic              div_done,
    input  logic [NUM_W-1:0]  div_quot,
    output logic              ready,
    output logic              done,
    output logic              sat_flag,
    output logic [DROP_W-1:0] drop_count,
    output logic              clr_en,
    output logic [BIN_W-1:0]  bin_idx,
    output logic [CH_W-1:0]   cmp_chan,
    output logic              div_start,
    output logic [NUM_W-1:0]  div_num,
    output logic [CNT_W-1:0]  div_den,
    output logic              res_we,
    output logic [DNL_W-1:0]  res_dnl,
    output logic [INL_W-1:0]  res_inl
);
    localparam int               DNL_MAX   = (2 ** (DNL_W - 1)) - 1;
    localparam logic [NUM_W-1:0] DNL_MAX_N = NUM_W'(DNL_MAX);
    localparam logic [DNL_W-1:0] DNL_MAX_D = DNL_W'(DNL_MAX);
    localparam logic [BIN_W-1:0] LAST_BIN  = BIN_W'(NUM_BINS - 1);

    cdh_state_e        state_q;
    logic [BIN_W-1:0]  bin_q;
    logic [CH_W-1:0]   chan_q;
    logic              neg_q;
    logic [NUM_W-1:0]  quo_q;
    logic [INL_W-1:0]  inl_q;
    logic              done_q;
    logic              sat_q;
    logic [DROP_W-1:0] drop_q;

    logic              clear_go;
    logic              comp_go;
    logic              last_bin;
    logic              neg;
    logic [CNT_W-1:0]  mag;
    logic [DNL_W-1:0]  mag_c;
    logic [DNL_W-1:0]  dnl_v;
    logic [INL_W-1:0]  inl_v;

    // Purpose: command acceptance; clear wins over compute.
    always_comb begin
        ready    = (state_q == ST_IDLE);
        clear_go = ready && clear_req;
        comp_go  = ready && compute_req && !clear_req;
        last_bin = (bin_q == LAST_BIN);
    end

    // Purpose: deviation of the loaded count from the mean.
    always_comb begin
        neg = (cur_count < cur_mean);
        mag = neg ? (cur_mean - cur_count) : (cur_count - cur_mean);
    end

    // Purpose: clamp the quotient, apply the sign, extend the INL sum.
    always_comb begin
        mag_c = (quo_q > DNL_MAX_N) ? DNL_MAX_D : quo_q[DNL_W-1:0];
        dnl_v = neg_q ? (~mag_c + 1'b1) : mag_c;
        inl_v = inl_q + {{(INL_W-DNL_W){dnl_v[DNL_W-1]}}, dnl_v};
    end

    // Purpose: main sequence through clear and compute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bin_q   <= '0;
            chan_q  <= '0;
            neg_q   <= 1'b0;
            quo_q   <= '0;
            inl_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (clear_go) begin
                        state_q <= ST_CLEAR;
                        bin_q   <= '0;
                    end else if (comp_go) begin
                        state_q <= ST_LOAD;
                        bin_q   <= '0;
                        chan_q  <= compute_chan;
                        inl_q   <= '0;
                    end
                end
                ST_CLEAR: begin
                    bin_q <= bin_q + 1'b1;
                    if (last_bin) state_q <= ST_IDLE;
                end
                ST_LOAD: begin
                    neg_q <= neg;
                    if (cur_mean == '0) begin
                        quo_q   <= '0;
                        state_q <= ST_STORE;
                    end else begin
                        state_q <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        quo_q   <= div_quot;
                        state_q <= ST_STORE;
                    end
                end
                ST_STORE: begin
                    inl_q <= inl_v;
                    bin_q <= bin_q + 1'b1;
                    state_q <= last_bin ? ST_IDLE : ST_LOAD;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: completion flag, cleared by any accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     done_q <= 1'b0;
        else if (clear_go || comp_go)                   done_q <= 1'b0;
        else if (state_q == ST_STORE && last_bin)       done_q <= 1'b1;
    end

    // Purpose: sticky saturation flag, cleared by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        sat_q <= 1'b0;
        else if (clear_go) sat_q <= 1'b0;
        else if (sat_any)  sat_q <= 1'b1;
    end

    // Purpose: saturating count of hits refused while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_q <= '0;
        else if (hit_valid && !ready && (drop_q != {DROP_W{1'b1}}))
            drop_q <= drop_q + 1'b1;
    end

    assign done       = done_q;
    assign sat_flag   = sat_q;
    assign drop_count = drop_q;
    assign clr_en     = (state_q == ST_CLEAR);
    assign bin_idx    = bin_q;
    assign cmp_chan   = chan_q;
    assign div_start  = (state_q == ST_LOAD) && (cur_mean != '0);
    assign div_num    = {mag, {FRAC_W{1'b0}}};
    assign div_den    = cur_mean;
    assign res_we     = (state_q == ST_STORE);
    assign res_dnl    = dnl_v;
    assign res_inl    = inl_v;
endmodule

// File: rtl/code_density_nl.sv
// Module: top of the code density nonlinearity calculator.
// It holds NUM_CH histogram banks, a shared divider, the result buffer and
// the sequencer, plus registered readout.
// Assumes: NUM_BINS and NUM_CH are powers of two; hit_chan < NUM_CH.
module code_density_nl #(
    parameter int NUM_CH   = 8,
    parameter int NUM_BINS = 128,
    parameter int CNT_W    = 24,
    parameter int FRAC_W   = 8,
    parameter int DNL_W    = 16,
    parameter int DROP_W   = 16,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int BIN_W   = $clog2(NUM_BINS),
    localparam int INL_W   = DNL_W + BIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [CH_W-1:0]   hit_chan,
    input  logic [BIN_W-1:0]  hit_code,
    input  logic              clear_req,
    input  logic              compute_req,
    input  logic [CH_W-1:0]   compute_chan,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic [BIN_W-1:0]  rd_bin,
    output logic [CNT_W-1:0]  rd_count,
    output logic [DNL_W-1:0]  rd_dnl,
    output logic [INL_W-1:0]  rd_inl,
    output logic              ready,
    output logic              done,
    output logic              sat_flag,
    output logic [DROP_W-1:0] drop_count
);
    localparam int TOT_W = CNT_W + BIN_W;
    localparam int NUM_W = CNT_W + FRAC_W;

    logic             hit_take;
    logic             clr_en;
    logic [BIN_W-1:0] bin_idx;
    logic [CH_W-1:0]  cmp_chan;
    logic             div_start;
    logic [NUM_W-1:0] div_num;
    logic [CNT_W-1:0] div_den;
    logic             div_done;
    logic [NUM_W-1:0] div_quot;
    logic             res_we;
    logic [DNL_W-1:0] res_dnl;
    logic [INL_W-1:0] res_inl;
    logic [DNL_W-1:0] buf_dnl;
    logic [INL_W-1:0] buf_inl;
    logic [CNT_W-1:0] cnt_a [NUM_CH];
    logic [CNT_W-1:0] cnt_b [NUM_CH];
    logic [TOT_W-1:0] tot   [NUM_CH];
    logic [NUM_CH-1:0] sat_vec;
    logic             sat_any;
    logic [CNT_W-1:0] cur_count;
    logic [CNT_W-1:0] cur_mean;
    logic [TOT_W-1:0] cur_total;

    assign hit_take = hit_valid && ready;

    // One histogram bank per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        cdh_bank #(
            .NUM_BINS (NUM_BINS),
            .CNT_W    (CNT_W),
            .BIN_W    (BIN_W),
            .TOT_W    (TOT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_en    (clr_en),
            .clr_addr  (bin_idx),
            .inc_en    (hit_take && (hit_chan == CH_W'(g))),
            .inc_addr  (hit_code),
            .rd_a_addr (rd_bin),
            .rd_a_data (cnt_a[g]),
            .rd_b_addr (bin_idx),
            .rd_b_data (cnt_b[g]),
            .total     (tot[g]),
            .sat_hit   (sat_vec[g])
        );
    end

    // Purpose: select the channel under computation and derive its mean.
    always_comb begin
        sat_any   = |sat_vec;
        cur_count = cnt_b[cmp_chan];
        cur_total = tot[cmp_chan];
        cur_mean  = cur_total[TOT_W-1:BIN_W];
    end

    cdh_divider #(
        .NUM_W (NUM_W),
        .DEN_W (CNT_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_quot)
    );

    cdh_result #(
        .NUM_BINS (NUM_BINS),
        .BIN_W    (BIN_W),
        .DNL_W    (DNL_W),
        .INL_W    (INL_W)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_we),
        .wr_addr (bin_idx),
        .wr_dnl  (res_dnl),
        .wr_inl  (res_inl),
        .rd_addr (rd_bin),
        .rd_dnl  (buf_dnl),
        .rd_inl  (buf_inl)
    );

    cdh_ctrl #(
        .NUM_BINS (NUM_BINS),
        .CNT_W    (CNT_W),
        .FRAC_W   (FRAC_W),
        .DNL_W    (DNL_W),
        .DROP_W   (DROP_W),
        .CH_W     (CH_W),
        .BIN_W    (BIN_W),
        .NUM_W    (NUM_W),
        .INL_W    (INL_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_req    (clear_req),
        .compute_req  (compute_req),
        .compute_chan (compute_chan),
        .hit_valid    (hit_valid),
        .sat_any      (sat_any),
        .cur_count    (cur_count),
        .cur_mean     (cur_mean),
        .div_done     (div_done),
        .div_quot     (div_quot),
        .ready        (ready),
        .done         (done),
        .sat_flag     (sat_flag),
        .drop_count   (drop_count),
        .clr_en       (clr_en),
        .bin_idx      (bin_idx),
        .cmp_chan     (cmp_chan),
        .div_start    (div_start),
        .div_num      (div_num),
        .div_den      (div_den),
        .res_we       (res_we),
        .res_dnl      (res_dnl),
        .res_inl      (res_inl)
    );

    // Purpose: register the readout port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_count <= '0;
            rd_dnl   <= '0;
            rd_inl   <= '0;
        end else begin
            rd_count <= cnt_a[rd_chan];
            rd_dnl   <= buf_dnl;
            rd_inl   <= buf_inl;
        end
    end
endmodule

// File: rtl/code_density_nl_chk.sv
// Module: cycle-level property checker, bound to code_density_nl.
// Assumes: it observes only the ports of the top module.
module code_density_nl_chk #(
    parameter int NUM_BINS = 128,
    parameter int DROP_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit_valid,
    input logic              clear_req,
    input logic              compute_req,
    input logic              ready,
    input logic              done,
    input logic              sat_flag,
    input logic [DROP_W-1:0] drop_count
);
    logic in_clear;
    int   busy_len;

    // Purpose: measure how long ready stays low after an accepted clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_clear <= 1'b0;
            busy_len <= 0;
        end else if (ready && clear_req) begin
            in_clear <= 1'b1;
            busy_len <= 0;
        end else if (!ready) begin
            busy_len <= busy_len + 1;
        end else begin
            in_clear <= 1'b0;
        end
    end

    AST_CLEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clear_req) |=> !ready); // R3
    AST_CLEAR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_clear && ready) |-> (busy_len == NUM_BINS)); // R3
    AST_COMPUTE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && compute_req && !clear_req) |=> !ready); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready); // R7
    AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (clear_req || compute_req)) |=> !done); // R7
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !ready && (drop_count != {DROP_W{1'b1}}))
        |=> (drop_count == DROP_W'($past(drop_count) + 1'b1))); // R4
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_valid || ready) |=> $stable(drop_count)); // R4
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !(ready && clear_req)) |=> sat_flag); // R2
    AST_SAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clear_req) |=> !sat_flag); // R2
endmodule

bind code_density_nl code_density_nl_chk #(
    .NUM_BINS (NUM_BINS),
    .DROP_W   (DROP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_valid   (hit_valid),
    .clear_req   (clear_req),
    .compute_req (compute_req),
    .ready       (ready),
    .done        (done),
    .sat_flag    (sat_flag),
    .drop_count  (drop_count)
);

// File: tb/code_density_nl_test.sv
// Bench: random hit streams with a fixed seed, plus directed corner cases.
// Results are compared against a histogram model kept in the bench.
module code_density_nl_test;
    localparam int NCH   = 8;
    localparam int NB    = 128;
    localparam int CW    = 10;
    localparam int DW    = 16;
    localparam int IW    = 23;
    localparam int DRW   = 16;
    localparam int CMAX  = (1 << CW) - 1;
    localparam int DMAX  = (1 << (DW - 1)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hit_valid = 1'b0;
    logic [2:0]      hit_chan = '0;
    logic [6:0]      hit_code = '0;
    logic            clear_req = 1'b0;
    logic            compute_req = 1'b0;
    logic [2:0]      compute_chan = '0;
    logic [2:0]      rd_chan = '0;
    logic [6:0]      rd_bin = '0;
    logic [CW-1:0]   rd_count;
    logic [DW-1:0]   rd_dnl;
    logic [IW-1:0]   rd_inl;
    logic            ready;
    logic            done;
    logic            sat_flag;
    logic [DRW-1:0]  drop_count;

    int model [NCH][NB];
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    code_density_nl #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_chan(hit_chan),
        .hit_code(hit_code), .clear_req(clear_req), .compute_req(compute_req),
        .compute_chan(compute_chan), .rd_chan(rd_chan), .rd_bin(rd_bin),
        .rd_count(rd_count), .rd_dnl(rd_dnl), .rd_inl(rd_inl), .ready(ready),
        .done(done), .sat_flag(sat_flag), .drop_count(drop_count)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_bin(input int ch, input int bin, output int c, output int d, output int i);
        rd_chan = 3'(ch);
        rd_bin  = 7'(bin);
        @(negedge clk);
        c = int'(rd_count);
        d = int'($signed(rd_dnl));
        i = int'($signed(rd_inl));
    endtask

    function automatic int exp_dnl(int ch, int bin);
        int tot = 0;
        int mean, c, mag, q;
        for (int b = 0; b < NB; b++) tot += model[ch][b];
        mean = tot / NB;
        if (mean == 0) return 0;
        c   = model[ch][bin];
        mag = (c >= mean) ? c - mean : mean - c;
        q   = (mag * 256) / mean;
        if (q > DMAX) q = DMAX;
        return (c < mean) ? -q : q;
    endfunction

    task automatic verify_counts(input string req, input int ch);
        int c, d, i;
        for (int b = 0; b < NB; b++) begin
            read_bin(ch, b, c, d, i);
            chk(req, c, model[ch][b]);
        end
    endtask

    task automatic verify_nl(input int ch);
        int c, d, i, e;
        int acc = 0;
        for (int b = 0; b < NB; b++) begin
            read_bin(ch, b, c, d, i);
            e = exp_dnl(ch, b);
            acc += e;
            chk("R5 R10 dnl", d, e);
            chk("R6 R10 inl", i, acc);
        end
    endtask

    task automatic hit(input int ch, input int code);
        hit_valid = 1'b1;
        hit_chan  = 3'(ch);
        hit_code  = 7'(code);
        if (model[ch][code] < CMAX) model[ch][code]++;
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic run_compute(input int ch, input bit with_drops);
        int d0 = int'(drop_count);
        int drops = 0;
        int guard = 0;
        compute_req  = 1'b1;
        compute_chan = 3'(ch);
        @(negedge clk);
        compute_req = 1'b0;
        chk("R8 ready low in compute", ready, 0);
        while (!done && guard < 20000) begin
            if (with_drops && ($urandom % 2 == 0)) begin
                hit_valid = 1'b1;
                hit_chan  = 3'($urandom % NCH);
                hit_code  = 7'($urandom % NB);
                drops++;
            end else begin
                hit_valid = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        hit_valid = 1'b0;
        chk("R7 done after compute", done, 1);
        chk("R7 ready after compute", ready, 1);
        chk("R4 drop count", drop_count, d0 + drops);
    endtask

    initial begin
        int c, d, i, n;
        void'($urandom(32'd2718));
        for (int ch = 0; ch < NCH; ch++)
            for (int b = 0; b < NB; b++) model[ch][b] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1)
        chk("R1 ready after reset", ready, 1);
        chk("R1 done after reset", done, 0);
        chk("R1 sat after reset", sat_flag, 0);
        chk("R1 drops after reset", drop_count, 0);
        read_bin(2, 5, c, d, i);
        chk("R1 count after reset", c, 0);

        // Random hits, skewed toward low codes (R1, R11)
        for (int k = 0; k < 2500; k++) begin
            if ($urandom % 4 != 0) begin
                hit_valid = 1'b1;
                hit_chan  = 3'($urandom % NCH);
                hit_code  = 7'(($urandom % 3 == 0) ? ($urandom % 16) : ($urandom % NB));
                model[hit_chan][hit_code]++;
            end else begin
                hit_valid = 1'b0;
            end
            @(negedge clk);
        end
        hit_valid = 1'b0;
        for (int ch = 0; ch < NCH; ch++) verify_counts("R1 R11 count", ch);

        // Compute with hits arriving while busy (R4, R5, R6, R7, R8)
        run_compute(3, 1'b1);
        verify_counts("R8 frozen count", 3);
        verify_nl(3);
        run_compute(0, 1'b0);
        verify_nl(0);

        // Saturation (R2)
        for (int k = 0; k < 1100; k++) hit(5, 9);
        read_bin(5, 9, c, d, i);
        chk("R2 saturated count", c, CMAX);
        chk("R2 sat flag set", sat_flag, 1);
        hit(1, 0);
        chk("R2 sat flag sticky", sat_flag, 1);
        run_compute(5, 1'b0);
        verify_nl(5);
        chk("R2 sat flag after compute", sat_flag, 1);

        // Clear and compute in the same cycle (R3, R9)
        clear_req    = 1'b1;
        compute_req  = 1'b1;
        compute_chan = 3'd2;
        @(negedge clk);
        clear_req   = 1'b0;
        compute_req = 1'b0;
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R3 clear busy cycles", n, NB);
        chk("R9 done stays low", done, 0);
        chk("R2 sat cleared", sat_flag, 0);
        repeat (3) @(negedge clk);
        chk("R9 no compute after clear", ready, 1);
        chk("R9 done still low", done, 0);
        for (int ch = 0; ch < NCH; ch++)
            for (int b = 0; b < NB; b++) model[ch][b] = 0;
        for (int ch = 0; ch < NCH; ch++) verify_counts("R3 cleared count", ch);

        // Single heavy bin: DNL clamp (R5)
        for (int k = 0; k < 200; k++) hit(7, 0);
        run_compute(7, 1'b0);
        read_bin(7, 0, c, d, i);
        chk("R5 clamped dnl", d, DMAX);
        verify_nl(7);

        // Mean of zero: DNL all zero (R5)
        for (int k = 0; k < 50; k++) hit(6, k % 20);
        run_compute(6, 1'b0);
        verify_nl(6);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule